// File: doc/BRIEF.md
# Graphics Command Register Bank

This block is the processor-facing front end of a small pixel-drawing coprocessor. The host writes byte-wide parameter registers: a 16-bit source/length word written as two separate bytes, a command byte, three colour-plane bytes, two position bytes, two scroll bytes and a control byte. The bank holds all of them and presents them to the drawing engines as parallel outputs.

Commands are not started by a separate "go" write. Each command code has one parameter register whose write starts it. That is the last parameter the command needs. When that write lands and the engine is idle, the bank issues a one-cycle start strobe along with the 3-bit code.

The bank also keeps three event flags: frame blanking, foreground collision and background collision. It combines them into one interrupt line. Collision coordinates and an active-low status byte can be read back. A flag clears as a side effect of reading its Y coordinate.

Top module: `gfx_cmd_regs`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the register named by `wr_addr`, visible at the outputs one cycle later: 0 source word low byte, 1 source word high byte, 2 command, 3 green, 4 position X, 5 position Y, 6 red, 7 blue, 8 scroll X, 9 scroll Y, 10 control.
- R2: Writing one byte of the 16-bit source word leaves the other byte unchanged.
- R3: The command code is bits [2:0] of the command register. `start` pulses for one cycle, in the cycle after the starting write, with `start_code` equal to that code. Code 6 starts on a write of the command register itself (using the newly written code). Code 3 starts on a write of offset 4. Code 4 starts on offset 5. Code 5 starts on offset 1. Codes 2 and 7 start on offset 7.
- R4: Codes 0 and 1 never start. A write to any offset other than the one named for the current code does not pulse `start`.
- R5: A starting write made while `engine_busy` is high produces no `start`.
- R6: `irq` is high while the blanking flag is set, or the foreground flag is set, or the background flag is set and control bit 5 is 1.
- R7: Read offset 0 returns the foreground collision X and has no side effect. Read offset 1 returns the foreground collision Y and clears the foreground flag.
- R8: Read offset 2 returns the background collision X with bits [1:0] forced to 0. Read offset 3 returns the background collision Y and clears the background flag.
- R9: Read offset 4 returns status: bit 7 = `engine_busy`, bit 6 = NOT foreground flag, bit 5 = NOT blanking flag, bit 4 = NOT background flag, bit 3 = `raster_b8`, bits [2:0] = 0.
- R10: Read offsets 5 to 15 return 0.
- R11: Flag set inputs are single-cycle strobes that capture coordinates. When a set and a clear of the same flag fall in one cycle, the flag ends up set and holds the new coordinates.
- R12: A write to offset 11 clears the blanking flag, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (enables clear-on-read) |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| vblank_set | input | 1 | Frame blanking event strobe |
| fg_hit | input | 1 | Foreground collision strobe |
| fg_hit_x | input | 8 | Foreground collision X |
| fg_hit_y | input | 8 | Foreground collision Y |
| bg_hit | input | 1 | Background collision strobe |
| bg_hit_x | input | 8 | Background collision X |
| bg_hit_y | input | 8 | Background collision Y |
| engine_busy | input | 1 | Drawing engine busy |
| raster_b8 | input | 1 | Bit 8 of current raster line |
| irq | output | 1 | Combined interrupt |
| start | output | 1 | Command start strobe |
| start_code | output | 3 | Code of started command |
| src_word | output | 16 | Source/length word |
| cmd_byte | output | 8 | Command register |
| col_r | output | 8 | Red plane byte |
| col_g | output | 8 | Green plane byte |
| col_b | output | 8 | Blue plane byte |
| pos_x | output | 8 | Position X |
| pos_y | output | 8 | Position Y |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| ctrl_byte | output | 8 | Control register |

## Verification
The bench sweeps every command code against every write offset. A decoder that keyed on the wrong register, or that used the stale code when the command byte itself is rewritten, would miss a start or give a spurious one. All sixteen combinations of the three flags and the background enable bit are driven against `irq`, which catches a background flag that ignores its enable. The status byte's inverted polarity and the masked background X are checked after each flag change. A set strobe that coincides with a clear-on-read must leave the flag set, and an engine-busy window must swallow a start that would otherwise fire.

// File: rtl/gfx_regs_pkg.sv
package gfx_regs_pkg;

    localparam int DW      = 8;
    localparam int AW      = 4;
    localparam int CODE_W  = 3;
    localparam int SRC_W   = 2 * DW;
    localparam int BGX_LOW_ZERO = 2;
    localparam int IRQ_BG_EN_BIT = 5;
    localparam int NUM_HIT = 2;
    localparam int HIT_FG  = 0;
    localparam int HIT_BG  = 1;

    typedef enum logic [AW-1:0] {
        WO_SRC_LO = 4'd0,
        WO_SRC_HI = 4'd1,
        WO_CMD    = 4'd2,
        WO_GRN    = 4'd3,
        WO_PX     = 4'd4,
        WO_PY     = 4'd5,
        WO_RED    = 4'd6,
        WO_BLU    = 4'd7,
        WO_SCX    = 4'd8,
        WO_SCY    = 4'd9,
        WO_CTRL   = 4'd10,
        WO_VBCLR  = 4'd11
    } wr_off_e;

    typedef enum logic [AW-1:0] {
        RO_FG_X = 4'd0,
        RO_FG_Y = 4'd1,
        RO_BG_X = 4'd2,
        RO_BG_Y = 4'd3,
        RO_STAT = 4'd4
    } rd_off_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DW-1:0]    cmd;
        logic [DW-1:0]    grn;
        logic [DW-1:0]    px;
        logic [DW-1:0]    py;
        logic [DW-1:0]    red;
        logic [DW-1:0]    blu;
        logic [DW-1:0]    scx;
        logic [DW-1:0]    scy;
        logic [DW-1:0]    ctrl;
    } param_s;

    typedef struct packed {
        logic [DW-1:0] x;
        logic [DW-1:0] y;
    } coord_s;

    // True when a write to offset 'off' launches command 'code'.
    function automatic logic launches(input logic [CODE_W-1:0] code,
                                      input logic [AW-1:0] off);
        logic hit;
        case (code)
            3'd2, 3'd7: hit = (off == WO_BLU);
            3'd3:       hit = (off == WO_PX);
            3'd4:       hit = (off == WO_PY);
            3'd5:       hit = (off == WO_SRC_HI);
            3'd6:       hit = (off == WO_CMD);
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gfx_param_bank.sv
module gfx_param_bank
    import gfx_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output param_s        regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                WO_SRC_LO: regs.src[DW-1:0]     <= wr_data;
                WO_SRC_HI: regs.src[SRC_W-1:DW] <= wr_data;
                WO_CMD:    regs.cmd  <= wr_data;
                WO_GRN:    regs.grn  <= wr_data;
                WO_PX:     regs.px   <= wr_data;
                WO_PY:     regs.py   <= wr_data;
                WO_RED:    regs.red  <= wr_data;
                WO_BLU:    regs.blu  <= wr_data;
                WO_SCX:    regs.scx  <= wr_data;
                WO_SCY:    regs.scy  <= wr_data;
                WO_CTRL:   regs.ctrl <= wr_data;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gfx_start_decode.sv
module gfx_start_decode
    import gfx_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW-1:0]     cmd_now,
    input  logic              engine_busy,
    output logic              start,
    output logic [CODE_W-1:0] start_code
);

    logic [CODE_W-1:0] eff_code;
    logic              fire;

    // A write of the command byte must use the code being written.
    always_comb begin
        eff_code = (wr_addr == WO_CMD) ? wr_data[CODE_W-1:0] : cmd_now[CODE_W-1:0];
        fire     = wr_en && !engine_busy && launches(eff_code, wr_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start      <= 1'b0;
            start_code <= '0;
        end else begin
            start <= fire;
            if (fire) start_code <= eff_code;
        end
    end

endmodule

// File: rtl/gfx_hit_latch.sv
module gfx_hit_latch
    import gfx_regs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set,
    input  coord_s set_at,
    input  logic   clr,
    output logic   flag,
    output coord_s at
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            at   <= '0;
        end else if (set) begin
            flag <= 1'b1;
            at   <= set_at;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/gfx_status_unit.sv
module gfx_status_unit
    import gfx_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          vblank_set,
    input  logic [NUM_HIT-1:0] hit_set,
    input  coord_s        hit_at [NUM_HIT],
    input  logic          bg_irq_en,
    input  logic          engine_busy,
    input  logic          raster_b8,
    output logic [DW-1:0] rd_data,
    output logic          irq,
    output logic [NUM_HIT-1:0] hit_flag,
    output logic          vb_flag
);

    coord_s             hit_q   [NUM_HIT];
    logic [NUM_HIT-1:0] hit_clr;
    logic               vb_clr;

    always_comb begin
        hit_clr[HIT_FG] = rd_en && (rd_addr == RO_FG_Y);
        hit_clr[HIT_BG] = rd_en && (rd_addr == RO_BG_Y);
        vb_clr          = wr_en && (wr_addr == WO_VBCLR);
    end

    for (genvar h = 0; h < NUM_HIT; h++) begin : g_hit
        gfx_hit_latch u_latch (
            .clk    (clk),
            .rst    (rst),
            .set    (hit_set[h]),
            .set_at (hit_at[h]),
            .clr    (hit_clr[h]),
            .flag   (hit_flag[h]),
            .at     (hit_q[h])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)             vb_flag <= 1'b0;
        else if (vblank_set) vb_flag <= 1'b1;
        else if (vb_clr)     vb_flag <= 1'b0;
    end

    always_comb begin
        irq = vb_flag || hit_flag[HIT_FG] || (hit_flag[HIT_BG] && bg_irq_en);
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RO_FG_X: rd_data = hit_q[HIT_FG].x;
            RO_FG_Y: rd_data = hit_q[HIT_FG].y;
            RO_BG_X: rd_data = {hit_q[HIT_BG].x[DW-1:BGX_LOW_ZERO], {BGX_LOW_ZERO{1'b0}}};
            RO_BG_Y: rd_data = hit_q[HIT_BG].y;
            RO_STAT: rd_data = {engine_busy, ~hit_flag[HIT_FG], ~vb_flag,
                                ~hit_flag[HIT_BG], raster_b8, 3'b000};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gfx_cmd_regs.sv
module gfx_cmd_regs
    import gfx_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              vblank_set,
    input  logic              fg_hit,
    input  logic [DW-1:0]     fg_hit_x,
    input  logic [DW-1:0]     fg_hit_y,
    input  logic              bg_hit,
    input  logic [DW-1:0]     bg_hit_x,
    input  logic [DW-1:0]     bg_hit_y,
    input  logic              engine_busy,
    input  logic              raster_b8,
    output logic              irq,
    output logic              start,
    output logic [CODE_W-1:0] start_code,
    output logic [SRC_W-1:0]  src_word,
    output logic [DW-1:0]     cmd_byte,
    output logic [DW-1:0]     col_r,
    output logic [DW-1:0]     col_g,
    output logic [DW-1:0]     col_b,
    output logic [DW-1:0]     pos_x,
    output logic [DW-1:0]     pos_y,
    output logic [DW-1:0]     scroll_x,
    output logic [DW-1:0]     scroll_y,
    output logic [DW-1:0]     ctrl_byte
);

    param_s             regs;
    logic [NUM_HIT-1:0] hit_set;
    coord_s             hit_at [NUM_HIT];
    logic [NUM_HIT-1:0] hit_flag;
    logic               vb_flag;
    logic               fg_flag;
    logic               bg_flag;

    always_comb begin
        hit_set[HIT_FG]  = fg_hit;
        hit_set[HIT_BG]  = bg_hit;
        hit_at[HIT_FG]   = '{x: fg_hit_x, y: fg_hit_y};
        hit_at[HIT_BG]   = '{x: bg_hit_x, y: bg_hit_y};
        fg_flag          = hit_flag[HIT_FG];
        bg_flag          = hit_flag[HIT_BG];
    end

    gfx_param_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    gfx_start_decode u_start (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cmd_now     (regs.cmd),
        .engine_busy (engine_busy),
        .start       (start),
        .start_code  (start_code)
    );

    gfx_status_unit u_stat (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .vblank_set  (vblank_set),
        .hit_set     (hit_set),
        .hit_at      (hit_at),
        .bg_irq_en   (regs.ctrl[IRQ_BG_EN_BIT]),
        .engine_busy (engine_busy),
        .raster_b8   (raster_b8),
        .rd_data     (rd_data),
        .irq         (irq),
        .hit_flag    (hit_flag),
        .vb_flag     (vb_flag)
    );

    always_comb begin
        src_word  = regs.src;
        cmd_byte  = regs.cmd;
        col_r     = regs.red;
        col_g     = regs.grn;
        col_b     = regs.blu;
        pos_x     = regs.px;
        pos_y     = regs.py;
        scroll_x  = regs.scx;
        scroll_y  = regs.scy;
        ctrl_byte = regs.ctrl;
    end

endmodule

// File: rtl/gfx_cmd_regs_chk.sv
module gfx_cmd_regs_chk
    import gfx_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic              rd_en,
    input logic [AW-1:0]     rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic              vblank_set,
    input logic              fg_hit,
    input logic              bg_hit,
    input logic              engine_busy,
    input logic              start,
    input logic [CODE_W-1:0] start_code,
    input logic              irq,
    input logic              fg_flag,
    input logic              bg_flag,
    input logic              vb_flag
);

    assert_start_after_write_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(wr_en));

    assert_no_low_code_R4: assert property (@(posedge clk) disable iff (rst)
        start |-> (start_code > 3'd1));

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        start |-> !$past(engine_busy));

    assert_fg_raises_irq_R6: assert property (@(posedge clk) disable iff (rst)
        fg_hit |=> irq);

    assert_fg_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == RO_FG_Y && !fg_hit) |=> !fg_flag);

    assert_bg_clear_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == RO_BG_Y && !bg_hit) |=> !bg_flag);

    assert_bgx_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == RO_BG_X) |-> (rd_data[1:0] == 2'b00));

    assert_status_low_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == RO_STAT) |-> (rd_data[2:0] == 3'b000));

    assert_undef_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_addr > RO_STAT) |-> (rd_data == '0));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (fg_hit || bg_hit) |=> (fg_flag || bg_flag));

    assert_vb_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        vblank_set |=> vb_flag);

    assert_vb_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == WO_VBCLR && !vblank_set) |=> !vb_flag);

endmodule

bind gfx_cmd_regs gfx_cmd_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .vblank_set  (vblank_set),
    .fg_hit      (fg_hit),
    .bg_hit      (bg_hit),
    .engine_busy (engine_busy),
    .start       (start),
    .start_code  (start_code),
    .irq         (irq),
    .fg_flag     (fg_flag),
    .bg_flag     (bg_flag),
    .vb_flag     (vb_flag)
);

// File: tb/gfx_cmd_regs_bench.sv
module gfx_cmd_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        vblank_set = 1'b0;
    logic        fg_hit = 1'b0;
    logic [7:0]  fg_hit_x = '0;
    logic [7:0]  fg_hit_y = '0;
    logic        bg_hit = 1'b0;
    logic [7:0]  bg_hit_x = '0;
    logic [7:0]  bg_hit_y = '0;
    logic        engine_busy = 1'b0;
    logic        raster_b8 = 1'b0;
    logic        irq;
    logic        start;
    logic [2:0]  start_code;
    logic [15:0] src_word;
    logic [7:0]  cmd_byte, col_r, col_g, col_b, pos_x, pos_y;
    logic [7:0]  scroll_x, scroll_y, ctrl_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gfx_cmd_regs u_gfx_cmd_regs (.*);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic vb, input logic fg, input logic bg,
                         input logic [7:0] x, input logic [7:0] y);
        vblank_set = vb; fg_hit = fg; bg_hit = bg;
        fg_hit_x = x; fg_hit_y = y; bg_hit_x = x; bg_hit_y = y;
        @(posedge clk); @(negedge clk);
        vblank_set = 1'b0; fg_hit = 1'b0; bg_hit = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        rd(4'd1, d); rd(4'd3, d); wr(4'd11, 8'h00);
    endtask

    function automatic logic exp_launch(input int code, input int off);
        case (code)
            2, 7:    return off == 7;
            3:       return off == 4;
            4:       return off == 5;
            5:       return off == 1;
            6:       return off == 2;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic exp_irq;
        logic [7:0] exp_st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(4'd4, d);
        chk(d == 8'h70, "R9 reset status", d, 8'h70);
        chk(irq == 1'b0 && start == 1'b0, "R6 reset irq/start", {irq, start}, 0);
        chk(src_word == 16'h0 && ctrl_byte == 8'h0, "R1 reset regs", src_word, 0);

        // R1 / R2: register loads, several patterns
        for (int p = 0; p < 4; p++) begin
            logic [7:0] base;
            base = 8'h11 * (p + 1) + 8'h05;
            wr(4'd2, 8'h00);
            for (int k = 0; k < 11; k++) begin
                if (k != 2) wr(k[3:0], base + 8'(k));
            end
            chk(src_word == {base + 8'd1, base}, "R1 src word", src_word, {base + 8'd1, base});
            chk(col_g == base + 8'd3 && pos_x == base + 8'd4 && pos_y == base + 8'd5,
                "R1 green/pos", {col_g, pos_x, pos_y}, {base + 8'd3, base + 8'd4, base + 8'd5});
            chk(col_r == base + 8'd6 && col_b == base + 8'd7, "R1 red/blue",
                {col_r, col_b}, {base + 8'd6, base + 8'd7});
            chk(scroll_x == base + 8'd8 && scroll_y == base + 8'd9 && ctrl_byte == base + 8'd10,
                "R1 scroll/ctrl", {scroll_x, scroll_y, ctrl_byte},
                {base + 8'd8, base + 8'd9, base + 8'd10});
            wr(4'd0, 8'hA5);
            chk(src_word == {base + 8'd1, 8'hA5}, "R2 low byte only", src_word, {base + 8'd1, 8'hA5});
            wr(4'd1, 8'h3C);
            chk(src_word == 16'h3CA5, "R2 high byte only", src_word, 16'h3CA5);
        end
        wr(4'd2, 8'h00);
        wr(4'd2, 8'h5A);
        chk(cmd_byte == 8'h5A, "R1 command byte", cmd_byte, 8'h5A);

        // R3 / R4: every code against every write offset
        for (int code = 0; code < 8; code++) begin
            wr(4'd2, 8'h70 | 8'(code));
            chk(start == exp_launch(code, 2), "R3 R4 command write start", start, exp_launch(code, 2));
            if (start) chk(start_code == 3'(code), "R3 code on cmd write", start_code, code);
            @(negedge clk);
            chk(start == 1'b0, "R3 single-cycle strobe", start, 0);
            for (int k = 0; k < 11; k++) begin
                if (k != 2) begin
                    wr(k[3:0], 8'h20);
                    chk(start == exp_launch(code, k), "R3 R4 param write start",
                        start, exp_launch(code, k));
                    if (exp_launch(code, k))
                        chk(start_code == 3'(code), "R3 start code", start_code, code);
                end
            end
        end
        wr(4'd10, 8'h00);

        // R5: busy suppresses start
        wr(4'd2, 8'h72);
        engine_busy = 1'b1;
        wr(4'd7, 8'h01);
        chk(start == 1'b0, "R5 start while busy", start, 0);
        wr(4'd2, 8'h76);
        chk(start == 1'b0, "R5 code 6 while busy", start, 0);
        engine_busy = 1'b0;
        wr(4'd2, 8'h76);
        chk(start == 1'b1 && start_code == 3'd6, "R5 start once idle", {start, start_code}, 4'hE);

        // R6 / R9: all combinations of flags and bg enable
        for (int m = 0; m < 16; m++) begin
            logic vb, fg, bg, en;
            {en, bg, fg, vb} = 4'(m);
            clear_all();
            wr(4'd10, en ? 8'h20 : 8'h00);
            pulse(vb, fg, bg, 8'h40 + 8'(m), 8'h80 + 8'(m));
            exp_irq = vb | fg | (bg & en);
            chk(irq == exp_irq, "R6 irq combine", irq, exp_irq);
            rd(4'd4, d);
            exp_st = {1'b0, ~fg, ~vb, ~bg, 1'b0, 3'b000};
            chk(d == exp_st, "R9 status flags", d, exp_st);
        end

        // R9: busy and raster bits
        clear_all();
        engine_busy = 1'b1; raster_b8 = 1'b1;
        rd(4'd4, d);
        chk(d == 8'hF8, "R9 busy and raster", d, 8'hF8);
        engine_busy = 1'b0; raster_b8 = 1'b0;

        // R7: foreground readback and clear
        pulse(1'b0, 1'b1, 1'b0, 8'h9B, 8'h37);
        rd(4'd0, d);
        chk(d == 8'h9B, "R7 fg x", d, 8'h9B);
        chk(irq == 1'b1, "R7 fg x read keeps flag", irq, 1);
        rd(4'd1, d);
        chk(d == 8'h37, "R7 fg y", d, 8'h37);
        chk(irq == 1'b0, "R7 fg cleared by y read", irq, 0);

        // R8: background readback, mask and clear
        wr(4'd10, 8'h20);
        for (int x = 0; x < 256; x += 37) begin
            pulse(1'b0, 1'b0, 1'b1, 8'(x), 8'(255 - x));
            rd(4'd2, d);
            chk(d == (8'(x) & 8'hFC), "R8 bg x masked", d, 8'(x) & 8'hFC);
            chk(irq == 1'b1, "R8 bg x read keeps flag", irq, 1);
            rd(4'd3, d);
            chk(d == 8'(255 - x), "R8 bg y", d, 8'(255 - x));
            chk(irq == 1'b0, "R8 bg cleared by y read", irq, 0);
        end

        // R10: undefined reads
        pulse(1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
        for (int a = 5; a < 16; a++) begin
            rd(4'(a), d);
            chk(d == 8'h00, "R10 undefined read", d, 0);
        end

        // R11: set and clear in the same cycle
        clear_all();
        pulse(1'b0, 1'b1, 1'b0, 8'h11, 8'h22);
        rd_en = 1'b1; rd_addr = 4'd1; fg_hit = 1'b1; fg_hit_x = 8'h55; fg_hit_y = 8'h66;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; fg_hit = 1'b0;
        rd(4'd4, d);
        chk(d[6] == 1'b0, "R11 fg set wins", d[6], 0);
        rd(4'd0, d);
        chk(d == 8'h55, "R11 new fg x", d, 8'h55);
        clear_all();
        wr_en = 1'b1; wr_addr = 4'd11; wr_data = 8'h00; vblank_set = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; vblank_set = 1'b0;
        chk(irq == 1'b1, "R11 vblank set wins", irq, 1);

        // R12: vblank clear, any data
        wr(4'd11, 8'hFF);
        chk(irq == 1'b0, "R12 vblank cleared", irq, 0);
        pulse(1'b1, 1'b0, 1'b0, 8'h0, 8'h0);
        wr(4'd11, 8'h5A);
        rd(4'd4, d);
        chk(d[5] == 1'b1, "R12 status after clear", d[5], 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule